// File: doc/BRIEF.md
# H-Bridge Control Decoder with Fault Latch

This block is the digital control core of one full H-bridge. Each half-bridge leg has its own polarity input. When the bridge is allowed to run, each leg drives its high-side switch if its polarity input is high and its low-side switch if it is low. Equal polarities on both legs give the two braking states, with both high sides or both low sides conducting. Two disable inputs of opposite polarity, a sleep/enable input and an undervoltage level can each force every switch off. The gate enables are registered and change at the first clock edge after the inputs do.

Short-circuit and overtemperature pulses from the power stage trip a latch. While the latch is set, all switches stay off whatever the polarity inputs do, and the registered active-low fault flag stays low. Only a releasing edge on one of the disable inputs clears the latch: the active-high disable falling, or the active-low disable rising. A rising wake edge is checked in the same way, so a trip does not outlast a sleep period unless its cause is still there. An overtemperature trip stays latched while the cooled-down indication is false. Undervoltage is not latched: it turns the switches off and pulls the flag low only while it lasts.

Each leg waits a parameterised dead time before it changes from one side to the other, so its two switches are never on together.

Top module: `hbridge_ctrl`

## Requirements
- R1: While reset is asserted and at the first sample after it is released, every high-side and low-side enable is 0 and fault_n is 1.
- R2: With the bridge allowed to run, a leg whose polarity bit is 1 has hs_on=1, ls_on=0, and a leg whose polarity bit is 0 has hs_on=0, ls_on=1. Leg index g is controlled by pol_in[g].
- R3: Polarity 2'b00 turns on both low-side switches and polarity 2'b11 turns on both high-side switches (braking).
- R4: off_hi=1 or off_lo_n=0 forces all enables to 0 from the next clock edge, whatever the polarity inputs are.
- R5: wake=0 forces all enables to 0 from the next clock edge. Treat an undriven wake as 0.
- R6: A one-cycle sc_evt or ot_evt pulse turns all enables off and fault_n low at the next edge. Both stay that way after the pulse ends and do not follow changes of the polarity inputs.
- R7: A latched trip is cleared by off_hi falling 1→0 or off_lo_n rising 0→1. At that edge fault_n returns to 1 and the enables follow the inputs again.
- R8: After an ot_evt trip, a releasing disable edge leaves the latch set while temp_ok=0. The same edge clears it when temp_ok=1.
- R9: uv_lvl=1 turns all enables off and fault_n low from the next edge. When uv_lvl returns to 0, operation and fault_n=1 come back at the next edge with no disable edge.
- R10: When a leg changes from one side to the other, both of its switches are off for exactly DEAD_CYC cycles. hs_on[g] and ls_on[g] are never 1 together.
- R11: A rising wake edge clears a latched short-circuit trip. An overtemperature trip stays latched across the wake edge if temp_ok=0.
- R12: A trip pulse in the same cycle as a releasing edge wins: the latch stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pol_in | input | LEGS | Polarity request per leg, 1 = high side |
| off_hi | input | 1 | Disable, active high |
| off_lo_n | input | 1 | Disable, active low |
| wake | input | 1 | Enable; 0 = sleep |
| uv_lvl | input | 1 | Undervoltage level from the supply monitor |
| sc_evt | input | 1 | Short-circuit detect pulse |
| ot_evt | input | 1 | Overtemperature detect pulse |
| temp_ok | input | 1 | Temperature below threshold minus hysteresis |
| hs_on | output | LEGS | High-side gate enable per leg |
| ls_on | output | LEGS | Low-side gate enable per leg |
| fault_n | output | 1 | Registered fault flag, active low |

## Verification
The trip latch has two functions that can land in the same cycle: setting the latch on a detect pulse, and clearing it on a releasing disable edge. The bench parks the bridge in a tripped state with off_hi high. In one cycle it then drops off_hi and raises sc_evt together. It judges by fault_n and the enables, which must stay tripped at that edge and after the pulse is gone. A second overlap pairs a clearing edge with a hot die: the latch must ignore the edge until temp_ok rises.

// File: rtl/hbc_pkg.sv
package hbc_pkg;

    // Side a leg last conducted on
    typedef enum logic {
        SIDE_LO = 1'b0,
        SIDE_HI = 1'b1
    } side_e;

    // Trip latch and edge-detect history
    typedef struct packed {
        logic held;          // trip latched
        logic hot_cause;     // latch includes an overtemperature trip
        logic off_hi_prev;   // previous active-high disable
        logic off_lo_n_prev; // previous active-low disable
        logic wake_prev;     // previous wake
        logic flag_n;        // registered fault flag
    } trip_state_t;

endpackage

// File: rtl/hbc_trip.sv
module hbc_trip
    import hbc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic off_hi,
    input  logic off_lo_n,
    input  logic wake,
    input  logic uv_lvl,
    input  logic sc_evt,
    input  logic ot_evt,
    input  logic temp_ok,
    output logic hold_now,
    output logic fault_n
);

    trip_state_t q, d;
    logic clr_edge, wake_edge, trip_in;

    always_comb begin
        d         = q;
        clr_edge  = (q.off_hi_prev & ~off_hi) | (~q.off_lo_n_prev & off_lo_n);
        wake_edge = wake & ~q.wake_prev;
        trip_in   = sc_evt | ot_evt;

        d.off_hi_prev   = off_hi;
        d.off_lo_n_prev = off_lo_n;
        d.wake_prev     = wake;

        if (trip_in) begin
            // a new trip wins over any release in the same cycle
            d.held      = 1'b1;
            d.hot_cause = (q.held & q.hot_cause) | ot_evt;
        end else if (q.held && (clr_edge || wake_edge)) begin
            if (!(q.hot_cause && !temp_ok)) begin
                d.held      = 1'b0;
                d.hot_cause = 1'b0;
            end
        end

        d.flag_n = ~(d.held | uv_lvl);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.held          <= 1'b0;
            q.hot_cause     <= 1'b0;
            q.off_hi_prev   <= 1'b0;
            q.off_lo_n_prev <= 1'b1;
            q.wake_prev     <= 1'b0;
            q.flag_n        <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign hold_now = d.held;
    assign fault_n  = q.flag_n;

    // R12
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sc_evt || ot_evt) |=> (q.held && !fault_n));

    // R7
    release_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(q.held) |-> $past(clr_edge || wake_edge));

    // R8
    hot_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.held && q.hot_cause && !temp_ok) |=> q.held);

    // R9
    uv_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        uv_lvl |=> !fault_n);

endmodule

// File: rtl/hbc_leg.sv
module hbc_leg
    import hbc_pkg::*;
#(
    parameter int DEAD_CYC = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic pol,
    output logic hs,
    output logic ls
);

    localparam int CW = (DEAD_CYC < 1) ? 1 : $clog2(DEAD_CYC + 1);
    localparam logic [CW-1:0] DEAD_V = CW'(DEAD_CYC);

    typedef struct packed {
        logic          hs;
        logic          ls;
        side_e         last;
        logic [CW-1:0] gap;   // consecutive all-off cycles, saturating
    } leg_state_t;

    leg_state_t q, d;
    logic may_hi, may_lo;

    always_comb begin
        d      = q;
        may_hi = (q.last == SIDE_HI) || (q.gap >= DEAD_V);
        may_lo = (q.last == SIDE_LO) || (q.gap >= DEAD_V);

        if (!run) begin
            d.hs = 1'b0;
            d.ls = 1'b0;
        end else if (pol) begin
            if (q.ls) begin
                d.ls = 1'b0;
                if (DEAD_CYC == 0) begin
                    d.hs   = 1'b1;
                    d.last = SIDE_HI;
                end
            end else if (!q.hs && may_hi) begin
                d.hs   = 1'b1;
                d.last = SIDE_HI;
            end
        end else begin
            if (q.hs) begin
                d.hs = 1'b0;
                if (DEAD_CYC == 0) begin
                    d.ls   = 1'b1;
                    d.last = SIDE_LO;
                end
            end else if (!q.ls && may_lo) begin
                d.ls   = 1'b1;
                d.last = SIDE_LO;
            end
        end

        if (d.hs || d.ls) begin
            d.gap = '0;
        end else if (q.gap < DEAD_V) begin
            d.gap = q.gap + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.hs   <= 1'b0;
            q.ls   <= 1'b0;
            q.last <= SIDE_LO;
            q.gap  <= DEAD_V;
        end else begin
            q <= d;
        end
    end

    assign hs = q.hs;
    assign ls = q.ls;

    // R10
    no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(q.hs && q.ls));

    // R10
    gap_lo_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (DEAD_CYC > 0 && $rose(q.ls)) |-> !$past(q.hs));

    // R10
    gap_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (DEAD_CYC > 0 && $rose(q.hs)) |-> !$past(q.ls));

endmodule

// File: rtl/hbridge_ctrl.sv
module hbridge_ctrl
    import hbc_pkg::*;
#(
    parameter int LEGS     = 2,
    parameter int DEAD_CYC = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [LEGS-1:0] pol_in,
    input  logic            off_hi,
    input  logic            off_lo_n,
    input  logic            wake,
    input  logic            uv_lvl,
    input  logic            sc_evt,
    input  logic            ot_evt,
    input  logic            temp_ok,
    output logic [LEGS-1:0] hs_on,
    output logic [LEGS-1:0] ls_on,
    output logic            fault_n
);

    logic hold_now;
    logic run;

    hbc_trip u_trip (
        .clk      (clk),
        .rst_n    (rst_n),
        .off_hi   (off_hi),
        .off_lo_n (off_lo_n),
        .wake     (wake),
        .uv_lvl   (uv_lvl),
        .sc_evt   (sc_evt),
        .ot_evt   (ot_evt),
        .temp_ok  (temp_ok),
        .hold_now (hold_now),
        .fault_n  (fault_n)
    );

    assign run = wake & ~off_hi & off_lo_n & ~uv_lvl & ~hold_now;

    for (genvar g = 0; g < LEGS; g++) begin : g_leg
        hbc_leg #(.DEAD_CYC(DEAD_CYC)) u_leg (
            .clk   (clk),
            .rst_n (rst_n),
            .run   (run),
            .pol   (pol_in[g]),
            .hs    (hs_on[g]),
            .ls    (ls_on[g])
        );
    end

    // R4
    disable_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (off_hi || !off_lo_n) |=> (hs_on == '0 && ls_on == '0));

    // R5
    sleep_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wake |=> (hs_on == '0 && ls_on == '0));

    // R6
    trip_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sc_evt || ot_evt) |=> (hs_on == '0 && ls_on == '0 && !fault_n));

    // R9
    uv_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        uv_lvl |=> (hs_on == '0 && ls_on == '0));

endmodule

// File: tb/hbridge_ctrl_test.sv
module hbridge_ctrl_test;

    localparam int CLK_PERIOD = 10;
    localparam int DEAD       = 3;
    localparam int SETTLE     = 8;
    localparam int NVEC       = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] pol_in = 2'b01;
    logic       off_hi = 1'b0, off_lo_n = 1'b1, wake = 1'b0;
    logic       uv_lvl = 1'b0, sc_evt = 1'b0, ot_evt = 1'b0, temp_ok = 1'b1;
    logic [1:0] hs_on, ls_on;
    logic       fault_n;

    int checks = 0;
    int fails  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    hbridge_ctrl #(.LEGS(2), .DEAD_CYC(DEAD)) uut (
        .clk(clk), .rst_n(rst_n), .pol_in(pol_in), .off_hi(off_hi),
        .off_lo_n(off_lo_n), .wake(wake), .uv_lvl(uv_lvl), .sc_evt(sc_evt),
        .ot_evt(ot_evt), .temp_ok(temp_ok), .hs_on(hs_on), .ls_on(ls_on),
        .fault_n(fault_n)
    );

    // {pol[1:0], off_hi, off_lo_n, wake, uv, exp_hs[1:0], exp_ls[1:0], exp_fault_n}
    localparam logic [10:0] VEC [NVEC] = '{
        11'b01_0_1_1_0_01_10_1,
        11'b10_0_1_1_0_10_01_1,
        11'b00_0_1_1_0_00_11_1,
        11'b11_0_1_1_0_11_00_1,
        11'b01_1_1_1_0_00_00_1,
        11'b10_0_0_1_0_00_00_1,
        11'b11_1_0_1_0_00_00_1,
        11'b01_0_1_0_0_00_00_1,
        11'b10_0_1_1_1_00_00_0,
        11'b10_0_1_1_0_10_01_1
    };

    function automatic string row_req(int i);
        case (i)
            0, 1:    return "R2";
            2, 3:    return "R3";
            4, 5, 6: return "R4";
            7:       return "R5";
            default: return "R9";
        endcase
    endfunction

    task automatic step(int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic chk(string req, string what, logic [4:0] exp);
        logic [4:0] act;
        act = {hs_on, ls_on, fault_n};
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual hs/ls/fn=%b expected=%b", req, what, act, exp);
        end
    endtask

    task automatic pulse_sc();
        sc_evt = 1'b1; step(1); sc_evt = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        fails++;
        $display("FAIL R1 watchdog actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        // R1 reset state
        step(2);
        chk("R1", "in reset", 5'b00_00_1);
        rst_n = 1'b1;
        step(1);
        chk("R1", "after release", 5'b00_00_1);

        // table walk: R2 R3 R4 R5 R9
        for (int i = 0; i < NVEC; i++) begin
            pol_in   = VEC[i][10:9];
            off_hi   = VEC[i][8];
            off_lo_n = VEC[i][7];
            wake     = VEC[i][6];
            uv_lvl   = VEC[i][5];
            step(SETTLE);
            chk(row_req(i), $sformatf("row %0d", i), VEC[i][4:0]);
        end

        // R10 dead time: leg0 high side -> low side
        pol_in = 2'b11; step(SETTLE);
        chk("R10", "pre", 5'b11_00_1);
        pol_in = 2'b10;
        for (int k = 1; k <= DEAD; k++) begin
            step(1);
            chk("R10", $sformatf("gap cycle %0d", k), 5'b10_00_1);
        end
        step(1);
        chk("R10", "low side after gap", 5'b10_01_1);

        // R6 short-circuit trip holds and ignores polarity
        pol_in = 2'b01; step(SETTLE);
        pulse_sc();
        chk("R6", "trip edge", 5'b00_00_0);
        step(3);
        chk("R6", "held after pulse", 5'b00_00_0);
        pol_in = 2'b10; step(3);
        chk("R6", "polarity ignored", 5'b00_00_0);

        // R7 release by off_hi falling
        off_hi = 1'b1; step(1);
        off_hi = 1'b0; step(1);
        chk("R7", "off_hi release", 5'b10_01_1);

        // R8 overtemperature with hot die
        temp_ok = 1'b0;
        ot_evt = 1'b1; step(1); ot_evt = 1'b0; step(2);
        off_lo_n = 1'b0; step(1);
        off_lo_n = 1'b1; step(1);
        chk("R8", "edge ignored while hot", 5'b00_00_0);
        temp_ok = 1'b1; step(1);
        off_lo_n = 1'b0; step(1);
        off_lo_n = 1'b1; step(1);
        chk("R8", "release when cool", 5'b10_01_1);

        // R11 wake edge clears short-circuit trip
        pulse_sc();
        wake = 1'b0; step(3);
        chk("R11", "asleep with trip", 5'b00_00_0);
        wake = 1'b1; step(1);
        chk("R11", "wake clears short trip", 5'b10_01_1);

        // R11 wake keeps overtemperature trip while hot
        temp_ok = 1'b0;
        ot_evt = 1'b1; step(1); ot_evt = 1'b0;
        wake = 1'b0; step(2);
        wake = 1'b1; step(1);
        chk("R11", "wake keeps hot trip", 5'b00_00_0);
        temp_ok = 1'b1;
        off_hi = 1'b1; step(1);
        off_hi = 1'b0; step(1);
        chk("R7", "release after cooling", 5'b10_01_1);

        // R12 trip and release in the same cycle
        pulse_sc();
        off_hi = 1'b1; step(1);
        off_hi = 1'b0; sc_evt = 1'b1; step(1);
        sc_evt = 1'b0;
        chk("R12", "coincident edge", 5'b00_00_0);
        step(2);
        chk("R12", "still latched", 5'b00_00_0);

        // R9 undervoltage over a latched trip, then release
        uv_lvl = 1'b1; step(2);
        uv_lvl = 1'b0; step(2);
        chk("R9", "uv end keeps trip", 5'b00_00_0);
        off_lo_n = 1'b0; step(1);
        off_lo_n = 1'b1; step(1);
        chk("R7", "final release", 5'b10_01_1);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule